// File: doc/BRIEF.md
# Timer Channel Compare Output Mode Unit

This block drives a single timer channel's output pin. It reacts to two compare-equality strobes. The first is the channel's own match strobe. The second is the period match strobe, which comes from the channel that sets the counter period. Both strobes are single-cycle pulses, already aligned to timer ticks.

A 3-bit mode input selects one of eight output behaviours:

- a direct software-driven level;
- three single-event actions: set, toggle and clear;
- four pulse-width modes, in which the period match restores the output and the channel match moves it.

In every mode except the software mode, the output changes only at a clock edge where the timer-tick enable is high. In the software mode the pin shows the software bit at once. The output register also loads the software bit on every clock, so that a later switch to another mode starts from the level software last drove.

When both strobes land on the same tick in a pulse-width mode, the period action wins. Counter generation, match detection and interrupt flags lie outside this block.

Top module: `timerOutMode`

## Requirements
- R1: With mode code 0, the output pin equals the software bit `swOut` in the same cycle, whatever the state of `tickEn`.
- R2: With a non-zero mode code, the output changes only at a rising clock edge where `tickEn` is 1. Strobes seen while `tickEn` is 0 leave the output unchanged.
- R3: Mode code 1: on a tick with `chEq` high, the output becomes 1.
- R4: Mode code 4: on a tick with `chEq` high, the output inverts.
- R5: Mode code 5: on a tick with `chEq` high, the output becomes 0.
- R6: Mode code 2: on a tick, `perEq` clears the output; otherwise `chEq` inverts it.
- R7: Mode code 3: on a tick, `perEq` clears the output; otherwise `chEq` sets it.
- R8: Mode code 6: on a tick, `perEq` sets the output; otherwise `chEq` inverts it.
- R9: Mode code 7: on a tick, `perEq` sets the output; otherwise `chEq` clears it.
- R10: In mode codes 2, 3, 6 and 7, when `chEq` and `perEq` are both high on the same tick, only the period action takes effect.
- R11: Mode codes 1, 4 and 5 ignore `perEq`. With `chEq` low the output holds.
- R12: While `rstN` is low with a non-zero mode, the output is 0.
- R13: After some time in mode code 0, a switch to a non-zero mode starts from the last `swOut` value sampled at a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Timer-tick enable, one cycle per timer tick |
| mode | input | 3 | Output mode code 0..7 |
| swOut | input | 1 | Software-written output bit |
| chEq | input | 1 | Channel compare-equality strobe |
| perEq | input | 1 | Period compare-equality strobe |
| outPin | output | 1 | Channel output |

## Verification
The block has no size parameters: the 3-bit mode field and single-bit strobes are its only configuration. The bench builds it as it stands and sweeps the whole input space of one step. That space is every mode code from 1 to 7, both prior output levels, all four strobe combinations and the tick enable on and off. Each prior level is seeded through mode 0. Separate cases cover immediate software drive, reset, and carrying the software level across a mode switch.

// File: rtl/tmrOutPkg.sv
package tmrOutPkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_SW      = 3'd0,
    MODE_SET     = 3'd1,
    MODE_TOG_CLR = 3'd2,
    MODE_SET_CLR = 3'd3,
    MODE_TOG     = 3'd4,
    MODE_CLR     = 3'd5,
    MODE_TOG_SET = 3'd6,
    MODE_CLR_SET = 3'd7
  } outMode_e;

  typedef struct packed {
    logic load;
    logic set;
    logic clr;
    logic tog;
  } outCmd_t;
endpackage

// File: rtl/outCtrl.sv
module outCtrl
  import tmrOutPkg::*;
(
  input  logic              tickEn,
  input  logic [MODE_W-1:0] mode,
  input  logic              chEq,
  input  logic              perEq,
  output outCmd_t           cmd
);
  outMode_e modeSel;
  assign modeSel = outMode_e'(mode);

  always_comb begin
    cmd = '0;
    if (modeSel == MODE_SW) begin
      cmd.load = 1'b1;
    end else if (tickEn) begin
      unique case (modeSel)
        MODE_SET: cmd.set = chEq;
        MODE_TOG: cmd.tog = chEq;
        MODE_CLR: cmd.clr = chEq;
        MODE_TOG_CLR: begin
          if (perEq) cmd.clr = 1'b1;
          else       cmd.tog = chEq;
        end
        MODE_SET_CLR: begin
          if (perEq) cmd.clr = 1'b1;
          else       cmd.set = chEq;
        end
        MODE_TOG_SET: begin
          if (perEq) cmd.set = 1'b1;
          else       cmd.tog = chEq;
        end
        MODE_CLR_SET: begin
          if (perEq) cmd.set = 1'b1;
          else       cmd.clr = chEq;
        end
        default: ;
      endcase
    end
  end

  // R10: at most one action strobe at a time
  always_comb begin
    a_r10_one_action: assert ($onehot0({cmd.load, cmd.set, cmd.clr, cmd.tog}));
  end
endmodule

// File: rtl/outReg.sv
module outReg
  import tmrOutPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  outCmd_t cmd,
  input  logic    swOut,
  output logic    outPin
);
  logic outQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         outQ <= 1'b0;
    else if (cmd.load) outQ <= swOut;
    else if (cmd.set)  outQ <= 1'b1;
    else if (cmd.clr)  outQ <= 1'b0;
    else if (cmd.tog)  outQ <= ~outQ;
  end

  assign outPin = cmd.load ? swOut : outQ;

  // R2: with no command the register holds
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == '0) |=> (outQ == $past(outQ)));
endmodule

// File: rtl/timerOutMode.sv
module timerOutMode
  import tmrOutPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [MODE_W-1:0] mode,
  input  logic              swOut,
  input  logic              chEq,
  input  logic              perEq,
  output logic              outPin
);
  outCmd_t cmd;

  outCtrl u_ctrl (
    .tickEn(tickEn), .mode(mode), .chEq(chEq), .perEq(perEq), .cmd(cmd)
  );

  outReg u_reg (
    .clk(clk), .rstN(rstN), .cmd(cmd), .swOut(swOut), .outPin(outPin)
  );

  // R3: mode 1 set on channel match
  a_r3_set: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd1 && tickEn && chEq) ##1 (mode != 3'd0) |-> outPin);
  // R5: mode 5 clear on channel match
  a_r5_clr: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd5 && tickEn && chEq) ##1 (mode != 3'd0) |-> !outPin);
  // R4: mode 4 toggles
  a_r4_tog: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd4 && tickEn && chEq) ##1 (mode != 3'd0) |-> outPin != $past(outPin));
  // R10: period match wins in clearing PWM modes
  a_r10_per_clr: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == 3'd2 || mode == 3'd3) && tickEn && perEq) ##1 (mode != 3'd0) |-> !outPin);
  // R10: period match wins in setting PWM modes
  a_r10_per_set: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == 3'd6 || mode == 3'd7) && tickEn && perEq) ##1 (mode != 3'd0) |-> outPin);
  // R2: no tick, output held across non-zero modes
  a_r2_no_tick: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 3'd0 && !tickEn) ##1 (mode != 3'd0) |-> $stable(outPin));
endmodule

// File: tb/test_timerOutMode.sv
module test_timerOutMode;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic [2:0] mode = 3'd1;
  logic swOut = 1'b0;
  logic chEq = 1'b0;
  logic perEq = 1'b0;
  logic outPin;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  timerOutMode i_timerOutMode (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .mode(mode), .swOut(swOut),
    .chEq(chEq), .perEq(perEq), .outPin(outPin)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: outPin=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic logic expOut(input int m, input logic p, input logic c,
                                  input logic e, input logic t);
    if (!t) return p;
    case (m)
      1: return c ? 1'b1 : p;
      4: return c ? ~p : p;
      5: return c ? 1'b0 : p;
      2: return e ? 1'b0 : (c ? ~p : p);
      3: return e ? 1'b0 : (c ? 1'b1 : p);
      6: return e ? 1'b1 : (c ? ~p : p);
      default: return e ? 1'b1 : (c ? 1'b0 : p);
    endcase
  endfunction

  function automatic string tagOf(input int m, input logic c, input logic e,
                                  input logic t);
    if (!t) return "R2";
    if ((m == 2 || m == 3 || m == 6 || m == 7) && c && e) return "R10";
    if ((m == 1 || m == 4 || m == 5) && e && !c) return "R11";
    case (m)
      1: return "R3";
      4: return "R4";
      5: return "R5";
      2: return "R6";
      3: return "R7";
      6: return "R8";
      7: return "R9";
      default: return "R11";
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: outPin=%0b expected=done", outPin);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    #3;
    check(outPin, 1'b0, "R12 reset");
    @(posedge clk); #1;
    check(outPin, 1'b0, "R12 reset held");
    @(negedge clk); rstN = 1'b1;

    // R1: mode 0 follows software bit immediately, no tick
    mode = 3'd0; tickEn = 1'b0; swOut = 1'b1; #1;
    check(outPin, 1'b1, "R1 sw high");
    swOut = 1'b0; #1;
    check(outPin, 1'b0, "R1 sw low");
    swOut = 1'b1; #1;
    check(outPin, 1'b1, "R1 sw high again");

    // R13: level carried out of mode 0
    @(posedge clk); @(negedge clk);
    mode = 3'd1; swOut = 1'b0;
    @(posedge clk); #1;
    check(outPin, 1'b1, "R13 carry high");
    @(negedge clk); mode = 3'd0; swOut = 1'b0;
    @(posedge clk); @(negedge clk); mode = 3'd4; swOut = 1'b1;
    @(posedge clk); #1;
    check(outPin, 1'b0, "R13 carry low");

    // exhaustive single-step sweep
    for (int m = 1; m < 8; m++) begin
      for (int p = 0; p < 2; p++) begin
        for (int s = 0; s < 8; s++) begin
          @(negedge clk);
          mode = 3'd0; swOut = p[0]; tickEn = 1'b0; chEq = 1'b0; perEq = 1'b0;
          @(negedge clk);
          mode = m[2:0]; swOut = ~p[0];
          chEq = s[0]; perEq = s[1]; tickEn = s[2];
          @(posedge clk); #1;
          check(outPin, expOut(m, p[0], s[0], s[1], s[2]),
                tagOf(m, s[0], s[1], s[2]));
        end
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule